// File: doc/BRIEF.md
# Biphase Line Data Acquisition Controller

This block sits between a video timing front end and a serial bus slave. The front end supplies sliced data samples, taken twice per bit cell, together with line-start and field-start strobes. The controller opens a capture window only on the configured data line. It pairs the half-cell samples into biphase cells and builds the line's bytes in a shadow buffer. If every cell on the line was well formed, and the bus is idle, it copies the whole buffer into a transfer register in one clock cycle.

The bus interface reads the transfer register one byte slot at a time through an index input. A slot beyond the captured bytes reads as all ones. An active-low ready flag tells the system controller that fresh data has been committed. A field flag follows the first and second field strobes. A test input makes both flags copy a strap pin.

Top module: `bpl_line_capture`

## Requirements
- R1: Half-cell samples are taken only after a line-start strobe whose line number equals DATA_LINE (default 16); samples on any other line leave the transfer register and the ready flag unchanged.
- R2: A cell is the pair (first half, second half). 1 then 0 decodes as logic 1 and 0 then 1 decodes as logic 0. Equal halves are an error, and a line with any erroneous cell is discarded, so the transfer register keeps its previous contents.
- R3: When the last of the NBYTES*8 cells of an error-free line is decoded, the whole line is copied into the transfer register in a single cycle and data_rdy_n_o goes low.
- R4: data_rdy_n_o is high after reset and goes high at the line-start strobe of the data line.
- R5: data_rdy_n_o goes high on the cycle after bus_nack_i, which marks a read that the master ended with a NACK.
- R6: A commit that falls in a cycle with bus_busy_i high is dropped, not queued; the register keeps its old contents and data_rdy_n_o stays high until the next error-free line commits.
- R7: field_id_o goes to 1 after field_first_i and to 0 after field_second_i; it is 0 after reset.
- R8: While test_en_i is 1, data_rdy_n_o and field_id_o both equal strap_i.
- R9: Within each byte the first cell received is byte bit 0. The bus presents the byte with its most significant bit first, so rd_byte_o[7] carries the first received cell of the slot and rd_byte_o[0] carries the eighth.
- R10: Slot indices NBYTES and above read 8'hFF.
- R11: After reset every data slot of the transfer register reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start_i | input | 1 | One-cycle strobe at the start of each video line |
| line_num_i | input | LINE_W | Number of the line that is starting |
| half_stb_i | input | 1 | Strobe marking a valid half-cell sample |
| half_val_i | input | 1 | Sliced half-cell sample value |
| field_first_i | input | 1 | Strobe at the start of the first field |
| field_second_i | input | 1 | Strobe at the start of the second field |
| bus_busy_i | input | 1 | High while the bus interface is accessing the block |
| bus_nack_i | input | 1 | Strobe: master NACKed to end a read |
| test_en_i | input | 1 | Test mode enable |
| strap_i | input | 1 | Strap level copied to the flags in test mode |
| rd_idx_i | input | IDX_W | Byte slot selected by the bus interface |
| rd_byte_o | output | 8 | Selected byte, MSB first for the bus |
| data_rdy_n_o | output | 1 | Active-low data-available flag |
| field_id_o | output | 1 | Field identity flag |

## Verification
The embedded properties check on every cycle that the transfer register stays frozen while the bus is busy and that the ready flag only falls right after an error-free line completes. They also check that the flag rises after a data-line start or a NACK, that the field flag follows its strobes, and that decoded cells only follow accepted half samples. The scenarios alone show the decoded byte values and bit order, that an error line or a non-data line is discarded, and that a dropped commit is not replayed. They also cover the padded slot and the test-mode override.

// File: rtl/bpl_pkg.sv
package bpl_pkg;

   function automatic logic [7:0] bpl_rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   function automatic int bpl_clog2_min1(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/bpl_cell_decoder.sv
module bpl_cell_decoder (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic en_i,
   input  logic half_stb_i,
   input  logic half_val_i,
   output logic cell_stb_o,
   output logic cell_bit_o,
   output logic cell_err_o
);
   logic phase_q;
   logic first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= 1'b0;
         first_q    <= 1'b0;
         cell_stb_o <= 1'b0;
         cell_bit_o <= 1'b0;
         cell_err_o <= 1'b0;
      end else begin
         cell_stb_o <= 1'b0;
         if (open_i) begin
            phase_q <= 1'b0;
         end else if (en_i && half_stb_i) begin
            if (!phase_q) begin
               first_q <= half_val_i;
               phase_q <= 1'b1;
            end else begin
               phase_q    <= 1'b0;
               cell_stb_o <= 1'b1;
               cell_bit_o <= first_q;
               cell_err_o <= (first_q == half_val_i);
            end
         end
      end
   end

   // R2: a decoded cell only ever follows an accepted half sample
   assert_cell_after_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cell_stb_o |-> $past(en_i && half_stb_i));

endmodule

// File: rtl/bpl_line_shadow.sv
module bpl_line_shadow #(
   parameter int NBYTES = 6,
   localparam int NCELLS = NBYTES * 8,
   localparam int CNT_W  = $clog2(NCELLS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_i,
   input  logic              close_i,
   input  logic              cell_stb_i,
   input  logic              cell_bit_i,
   input  logic              cell_err_i,
   output logic              active_o,
   output logic              done_o,
   output logic              ok_o,
   output logic [NCELLS-1:0] shadow_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             err_q;

   if (NBYTES < 1) begin : g_bad_nbytes
      $error("bpl_line_shadow: NBYTES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         err_q    <= 1'b0;
         active_o <= 1'b0;
         done_o   <= 1'b0;
         ok_o     <= 1'b0;
         shadow_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (open_i) begin
            cnt_q    <= '0;
            err_q    <= 1'b0;
            active_o <= 1'b1;
         end else if (close_i) begin
            active_o <= 1'b0;
         end else if (active_o && cell_stb_i) begin
            shadow_o[cnt_q] <= cell_bit_i;
            err_q           <= err_q | cell_err_i;
            cnt_q           <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(NCELLS - 1)) begin
               active_o <= 1'b0;
               done_o   <= 1'b1;
               ok_o     <= !(err_q || cell_err_i);
            end
         end
      end
   end

   // R3: completion is reported only right after a cell was stored
   assert_done_after_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(cell_stb_i && active_o));

endmodule

// File: rtl/bpl_xfer_regs.sv
module bpl_xfer_regs
   import bpl_pkg::*;
#(
   parameter int NBYTES    = 6,
   parameter int NSLOTS    = NBYTES + 1,
   parameter bit MSB_OUT   = 1'b1,
   localparam int NCELLS   = NBYTES * 8,
   localparam int IDX_W    = bpl_clog2_min1(NSLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic              ok_i,
   input  logic [NCELLS-1:0] shadow_i,
   input  logic              bus_busy_i,
   input  logic              rdy_set_i,
   input  logic              nack_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [7:0]        rd_byte_o,
   output logic              rdy_n_o
);
   logic [NCELLS-1:0] xfer_q;
   logic              commit;
   logic [7:0]        slot_byte [NSLOTS];

   if (NSLOTS < NBYTES) begin : g_bad_slots
      $error("bpl_xfer_regs: NSLOTS must not be below NBYTES");
   end

   assign commit = done_i && ok_i && !bus_busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_q  <= '0;
         rdy_n_o <= 1'b1;
      end else begin
         if (commit) xfer_q <= shadow_i;
         if (rdy_set_i || nack_i) rdy_n_o <= 1'b1;
         else if (commit)          rdy_n_o <= 1'b0;
      end
   end

   for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
      if (s < NBYTES) begin : g_data
         if (MSB_OUT) begin : g_rev
            assign slot_byte[s] = bpl_rev8(xfer_q[s*8 +: 8]);
         end else begin : g_str
            assign slot_byte[s] = xfer_q[s*8 +: 8];
         end
      end else begin : g_pad
         assign slot_byte[s] = 8'hFF;
      end
   end

   always_comb begin
      rd_byte_o = 8'hFF;
      if (int'(rd_idx_i) < NSLOTS) rd_byte_o = slot_byte[rd_idx_i];
   end

   // R6: the transfer register never changes under bus activity
   assert_frozen_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy_i |=> $stable(xfer_q));
   // R5: a NACK-ended read raises the ready flag
   assert_nack_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
      nack_i |=> rdy_n_o);
   // R4: the data-line start raises the ready flag
   assert_line_start_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_set_i |=> rdy_n_o);
   // R3: the ready flag falls only after an error-free line completes
   assert_fall_needs_good_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_n_o) |-> $past(done_i && ok_i));

endmodule

// File: rtl/bpl_line_capture.sv
module bpl_line_capture
   import bpl_pkg::*;
#(
   parameter int NBYTES    = 6,
   parameter int NSLOTS    = NBYTES + 1,
   parameter int LINE_W    = 9,
   parameter int DATA_LINE = 16,
   parameter bit MSB_OUT   = 1'b1,
   localparam int NCELLS   = NBYTES * 8,
   localparam int IDX_W    = bpl_clog2_min1(NSLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start_i,
   input  logic [LINE_W-1:0] line_num_i,
   input  logic              half_stb_i,
   input  logic              half_val_i,
   input  logic              field_first_i,
   input  logic              field_second_i,
   input  logic              bus_busy_i,
   input  logic              bus_nack_i,
   input  logic              test_en_i,
   input  logic              strap_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [7:0]        rd_byte_o,
   output logic              data_rdy_n_o,
   output logic              field_id_o
);
   logic              open_w, close_w, active_w;
   logic              cell_stb_w, cell_bit_w, cell_err_w;
   logic              done_w, ok_w;
   logic [NCELLS-1:0] shadow_w;
   logic              rdy_n_w;
   logic              field_q;

   if (DATA_LINE >= (1 << LINE_W)) begin : g_bad_line
      $error("bpl_line_capture: DATA_LINE does not fit in LINE_W bits");
   end

   assign open_w  = line_start_i && (line_num_i == LINE_W'(DATA_LINE));
   assign close_w = line_start_i && (line_num_i != LINE_W'(DATA_LINE));

   bpl_cell_decoder i_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_i     (open_w),
      .en_i       (active_w),
      .half_stb_i (half_stb_i),
      .half_val_i (half_val_i),
      .cell_stb_o (cell_stb_w),
      .cell_bit_o (cell_bit_w),
      .cell_err_o (cell_err_w)
   );

   bpl_line_shadow #(.NBYTES(NBYTES)) i_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_i     (open_w),
      .close_i    (close_w),
      .cell_stb_i (cell_stb_w),
      .cell_bit_i (cell_bit_w),
      .cell_err_i (cell_err_w),
      .active_o   (active_w),
      .done_o     (done_w),
      .ok_o       (ok_w),
      .shadow_o   (shadow_w)
   );

   bpl_xfer_regs #(.NBYTES(NBYTES), .NSLOTS(NSLOTS), .MSB_OUT(MSB_OUT)) i_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (done_w),
      .ok_i       (ok_w),
      .shadow_i   (shadow_w),
      .bus_busy_i (bus_busy_i),
      .rdy_set_i  (open_w),
      .nack_i     (bus_nack_i),
      .rd_idx_i   (rd_idx_i),
      .rd_byte_o  (rd_byte_o),
      .rdy_n_o    (rdy_n_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              field_q <= 1'b0;
      else if (field_first_i)  field_q <= 1'b1;
      else if (field_second_i) field_q <= 1'b0;
   end

   assign data_rdy_n_o = test_en_i ? strap_i : rdy_n_w;
   assign field_id_o   = test_en_i ? strap_i : field_q;

   // R7: field strobes set and clear the field flag
   assert_field_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      field_first_i |=> field_q);
   assert_field_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (field_second_i && !field_first_i) |=> !field_q);
   // R1: no cell is stored outside the data-line window
   assert_no_cells_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_w && !open_w) |=> $stable(shadow_w));

endmodule

// File: tb/test_bpl_line_capture.sv
module test_bpl_line_capture;
   import bpl_pkg::*;

   localparam int NB = 6;
   typedef logic [7:0] line_t [NB];
   typedef struct { int idx; logic [7:0] val; string req; } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_start = 1'b0;
   logic [8:0] line_num = '0;
   logic       half_stb = 1'b0, half_val = 1'b0;
   logic       ff1 = 1'b0, ff2 = 1'b0;
   logic       busy = 1'b0, nack = 1'b0;
   logic       test_en = 1'b0, strap = 1'b0;
   logic [2:0] rd_idx = '0;
   logic [7:0] rd_byte;
   logic       rdy_n, field_id;

   int errs = 0, checks = 0;
   bit finished = 1'b0;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   bpl_line_capture i_bpl_line_capture (
      .clk(clk), .rst_n(rst_n), .line_start_i(line_start), .line_num_i(line_num),
      .half_stb_i(half_stb), .half_val_i(half_val), .field_first_i(ff1),
      .field_second_i(ff2), .bus_busy_i(busy), .bus_nack_i(nack),
      .test_en_i(test_en), .strap_i(strap), .rd_idx_i(rd_idx),
      .rd_byte_o(rd_byte), .data_rdy_n_o(rdy_n), .field_id_o(field_id)
   );

   function automatic logic [7:0] flip(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver side of the scoreboard: expected slot contents
   task automatic push_line(input line_t d, input string req);
      for (int s = 0; s < NB; s++) exp_q.push_back('{s, flip(d[s]), req});
      exp_q.push_back('{NB, 8'hFF, "R10"});
   endtask

   // monitor side: read the slots and compare
   task automatic drain();
      while (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         rd_idx = 3'(e.idx);
         #1;
         chk(e.req, {24'd0, rd_byte}, {24'd0, e.val});
         @(negedge clk);
      end
   endtask

   task automatic send_line(input line_t d, input int bad, input logic [8:0] ln,
                            input bit chk_start);
      @(negedge clk);
      line_num = ln; line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      if (chk_start) chk("R4 rise at data line start", {31'd0, rdy_n}, 32'd1);
      for (int c = 0; c < NB * 8; c++) begin
         logic b, h2;
         b  = d[c/8][c%8];
         h2 = (c == bad) ? b : ~b;
         half_val = b;  half_stb = 1'b1; @(negedge clk); half_stb = 1'b0; @(negedge clk);
         half_val = h2; half_stb = 1'b1; @(negedge clk); half_stb = 1'b0; @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      line_t a, b, c, z;
      a = '{8'h3C, 8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00};
      b = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
      c = '{8'hE7, 8'h0F, 8'hF0, 8'h5A, 8'hC3, 8'h81};
      z = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 / R4 / R7 reset state
      chk("R4 ready high after reset", {31'd0, rdy_n}, 32'd1);
      chk("R7 field low after reset", {31'd0, field_id}, 32'd0);
      push_line(z, "R11"); drain();

      // good line: R3 commit, R2 decode, R9 bit order
      send_line(a, -1, 9'd16, 1'b1);
      chk("R3 ready low after good line", {31'd0, rdy_n}, 32'd0);
      push_line(a, "R9 R2 decode"); drain();

      // error in one cell: R2 discard
      send_line(b, 21, 9'd16, 1'b1);
      chk("R2 ready stays high after bad line", {31'd0, rdy_n}, 32'd1);
      push_line(a, "R2 kept after error"); drain();

      // non-data line: R1 ignored
      send_line(c, -1, 9'd15, 1'b0);
      chk("R1 ready unchanged off data line", {31'd0, rdy_n}, 32'd1);
      push_line(a, "R1 kept off data line"); drain();

      // bus busy: R6 commit dropped
      busy = 1'b1;
      send_line(b, -1, 9'd16, 1'b1);
      busy = 1'b0;
      repeat (4) @(negedge clk);
      chk("R6 ready high after dropped commit", {31'd0, rdy_n}, 32'd1);
      push_line(a, "R6 dropped not queued"); drain();

      // next good line updates
      send_line(c, -1, 9'd16, 1'b1);
      chk("R6 next good line commits", {31'd0, rdy_n}, 32'd0);
      push_line(c, "R6 R9 next line"); drain();

      // R5 NACK raises ready
      nack = 1'b1; @(negedge clk); nack = 1'b0;
      chk("R5 ready high after nack", {31'd0, rdy_n}, 32'd1);

      // R7 field flag
      ff1 = 1'b1; @(negedge clk); ff1 = 1'b0;
      chk("R7 field high after first", {31'd0, field_id}, 32'd1);
      ff2 = 1'b1; @(negedge clk); ff2 = 1'b0;
      chk("R7 field low after second", {31'd0, field_id}, 32'd0);

      // R8 test mode
      test_en = 1'b1; strap = 1'b1; #1;
      chk("R8 ready follows strap 1", {31'd0, rdy_n}, 32'd1);
      chk("R8 field follows strap 1", {31'd0, field_id}, 32'd1);
      strap = 1'b0; #1;
      chk("R8 ready follows strap 0", {31'd0, rdy_n}, 32'd0);
      chk("R8 field follows strap 0", {31'd0, field_id}, 32'd0);
      test_en = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule